// File: doc/BRIEF.md
# 64-bit Compare Timer

A bus-attached timer with a 32-bit register window. A free-running 64-bit up-counter advances once every P+1 clocks, where P is an 8-bit divide value held in the control word. A 64-bit comparator raises an event whenever it is enabled and the count has reached or passed its value. An event sets a sticky status flag that software clears by writing one. The flag drives a level interrupt when the interrupt enable is set.

For periodic operation, each event can add a programmable 32-bit step to the comparator. The comparator then re-arms itself. For one-shot operation, software reprograms the comparator after each event. The bus is single-cycle: a write takes effect at the clock edge where `bus_sel` and `bus_wr` are high. Read data is combinational from `bus_addr` while `bus_sel` is high and `bus_wr` is low. The counter is read as two independent halves, and no snapshot is taken.

Top module: `cmp_timer64`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low.
- R2: Byte offsets are as follows: 0x00 counter bits 31:0, 0x04 counter bits 63:32, 0x08 control, 0x0C status, 0x10 comparator bits 31:0, 0x14 comparator bits 63:32, 0x18 step. Control bit 0 is run, bit 1 compare enable, bit 2 interrupt enable, bit 3 auto-step enable, and bits 15:8 the divide value P. Unused control bits read zero. Any other offset reads zero, and a write to it changes nothing.
- R3: While run is set, the counter advances by one every P+1 clocks. While run is clear, it holds its value.
- R4: A write to either counter half loads it only when run is clear at that edge. Otherwise the write is ignored.
- R5: At each edge where compare enable is set and count >= comparator (unsigned, 64 bits), status bit 0 becomes 1.
- R6: While compare enable is clear, no event occurs and the status flag never rises, whatever the comparator holds.
- R7: Writing 1 to status bit 0 clears it, and writing 0 has no effect. If an event happens at the same edge, the event wins and the flag stays set.
- R8: With auto-step enabled, each event adds the 32-bit step value, zero-extended, to the comparator. A bus write to either comparator half in that cycle takes precedence.
- R9: `irq_o` is high exactly when the status flag and interrupt enable are both set. It stays high until one of them is cleared.
- R10: The carry out of the low counter half advances the high half in the same tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (5) | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when not reading |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench checks the greater-or-equal rule by placing the comparator below a count that is already running. A design that fired only on equality would never set the flag there. It writes the counter while running, which a design without the run lock would silently corrupt. It also clears the flag in the same cycle as a persistent match; a design where the clear wins would drop the flag and the interrupt. The bench steps the count across the low-half boundary to check the carry into the high half, and lets auto-step run several periods. A design that added the step twice, or skipped it, would show a wrong comparator on readback.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   // Byte offsets of the register window
   localparam int unsigned OFF_CNT_LO = 'h00;
   localparam int unsigned OFF_CNT_HI = 'h04;
   localparam int unsigned OFF_CTRL   = 'h08;
   localparam int unsigned OFF_STAT   = 'h0C;
   localparam int unsigned OFF_CMP_LO = 'h10;
   localparam int unsigned OFF_CMP_HI = 'h14;
   localparam int unsigned OFF_STEP   = 'h18;

   // Control word bit positions
   localparam int unsigned CB_RUN     = 0;
   localparam int unsigned CB_CMP     = 1;
   localparam int unsigned CB_IRQ     = 2;
   localparam int unsigned CB_STEP    = 3;
   localparam int unsigned CB_DIV_LSB = 8;
   localparam int unsigned DIV_MAX_W  = 8;

   typedef struct packed {
      logic step_en;
      logic irq_en;
      logic cmp_en;
      logic run;
   } tmr_ctl_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
   parameter int PSC_W = 8,
   localparam int DIV_W = (PSC_W > 0) ? PSC_W : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             tick_o
);
   generate
      if (PSC_W == 0) begin : g_bypass
         logic unused_div;
         assign unused_div = ^div_i;
         assign tick_o     = run_i;
      end else begin : g_div
         logic [DIV_W-1:0] pcnt_q;
         logic             at_lim;
         // >= so that lowering the divide value never strands the count
         assign at_lim = (pcnt_q >= div_i);
         assign tick_o = run_i & at_lim;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                pcnt_q <= '0;
            else if (!run_i || at_lim) pcnt_q <= '0;
            else                       pcnt_q <= pcnt_q + 1'b1;
         end

         // R3
         psc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (tick_o && (div_i != '0)) |=> (!tick_o || (div_i == '0)));
      end
   endgenerate
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
   parameter int HALF_W = 32,
   localparam int CNT_W = 2 * HALF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              ld_lo_i,
   input  logic              ld_hi_i,
   input  logic [HALF_W-1:0] ld_data_i,
   output logic [CNT_W-1:0]  cnt_o
);
   logic [1:0] inc;
   logic [1:0] ld;

   assign ld     = {ld_hi_i, ld_lo_i};
   assign inc[0] = tick_i;
   assign inc[1] = tick_i & (&cnt_o[HALF_W-1:0]);

   generate
      for (genvar h = 0; h < 2; h++) begin : g_half
         logic [HALF_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      q <= '0;
            else if (ld[h])  q <= ld_data_i;
            else if (inc[h]) q <= q + 1'b1;
         end
         assign cnt_o[h*HALF_W +: HALF_W] = q;
      end
   endgenerate

   // R3
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !(ld_lo_i || ld_hi_i)) |=> (cnt_o == $past(cnt_o) + CNT_W'(1)));
   // R3
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !(ld_lo_i || ld_hi_i)) |=> $stable(cnt_o));
endmodule

// File: rtl/tmr_compare.sv
module tmr_compare #(
   parameter int HALF_W = 32,
   localparam int CNT_W = 2 * HALF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic              en_i,
   input  logic              step_en_i,
   input  logic [HALF_W-1:0] step_i,
   input  logic              wr_lo_i,
   input  logic              wr_hi_i,
   input  logic [HALF_W-1:0] wdata_i,
   output logic [CNT_W-1:0]  cmp_o,
   output logic              hit_o
);
   logic [CNT_W-1:0] cmp_q;

   assign hit_o = en_i && (cnt_i >= cmp_q);
   assign cmp_o = cmp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q <= '0;
      end else if (wr_lo_i || wr_hi_i) begin
         if (wr_lo_i) cmp_q[HALF_W-1:0]     <= wdata_i;
         if (wr_hi_i) cmp_q[CNT_W-1:HALF_W] <= wdata_i;
      end else if (hit_o && step_en_i) begin
         cmp_q <= cmp_q + CNT_W'(step_i);
      end
   end

   // R8
   step_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_o && step_en_i && !wr_lo_i && !wr_hi_i)
         |=> (cmp_o == $past(cmp_o) + CNT_W'($past(step_i))));
   // R8
   step_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit_o && !wr_lo_i && !wr_hi_i) |=> $stable(cmp_o));
endmodule

// File: rtl/cmp_timer64.sv
module cmp_timer64
   import tmr_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int PSC_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq_o
);
   localparam int HALF_W = 32;
   localparam int CNT_W  = 2 * HALF_W;
   localparam int DIV_W  = (PSC_W > 0) ? PSC_W : 1;

   generate
      if (ADDR_W < 5) begin : g_bad_addr
         $error("ADDR_W must cover offset 0x18");
      end
      if (PSC_W > int'(DIV_MAX_W) || PSC_W < 0) begin : g_bad_psc
         $error("PSC_W must fit control bits 15:8");
      end
   endgenerate

   tmr_ctl_t         ctl_q;
   logic [DIV_W-1:0] div_q;
   logic [31:0]      step_q;
   logic             flag_q;
   logic             tick;
   logic             hit;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cmp;
   logic             wr_en;
   logic             wr_cnt_lo, wr_cnt_hi, wr_ctrl, wr_stat;
   logic             wr_cmp_lo, wr_cmp_hi, wr_step;
   logic [31:0]      ctrl_rd;
   logic [31:0]      rd_mux;

   assign wr_en     = bus_sel & bus_wr;
   assign wr_cnt_lo = wr_en && (bus_addr == ADDR_W'(OFF_CNT_LO));
   assign wr_cnt_hi = wr_en && (bus_addr == ADDR_W'(OFF_CNT_HI));
   assign wr_ctrl   = wr_en && (bus_addr == ADDR_W'(OFF_CTRL));
   assign wr_stat   = wr_en && (bus_addr == ADDR_W'(OFF_STAT));
   assign wr_cmp_lo = wr_en && (bus_addr == ADDR_W'(OFF_CMP_LO));
   assign wr_cmp_hi = wr_en && (bus_addr == ADDR_W'(OFF_CMP_HI));
   assign wr_step   = wr_en && (bus_addr == ADDR_W'(OFF_STEP));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q  <= '0;
         div_q  <= '0;
         step_q <= '0;
      end else begin
         if (wr_ctrl) begin
            ctl_q.run     <= bus_wdata[CB_RUN];
            ctl_q.cmp_en  <= bus_wdata[CB_CMP];
            ctl_q.irq_en  <= bus_wdata[CB_IRQ];
            ctl_q.step_en <= bus_wdata[CB_STEP];
            div_q         <= (PSC_W > 0) ? bus_wdata[CB_DIV_LSB +: DIV_W] : '0;
         end
         if (wr_step) step_q <= bus_wdata;
      end
   end

   // Event sets, write-one clears; a same-edge event wins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      flag_q <= 1'b0;
      else if (hit)                    flag_q <= 1'b1;
      else if (wr_stat && bus_wdata[0]) flag_q <= 1'b0;
   end

   tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (ctl_q.run),
      .div_i  (div_q),
      .tick_o (tick)
   );

   tmr_counter #(.HALF_W(HALF_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick),
      .ld_lo_i   (wr_cnt_lo & ~ctl_q.run),
      .ld_hi_i   (wr_cnt_hi & ~ctl_q.run),
      .ld_data_i (bus_wdata),
      .cnt_o     (cnt)
   );

   tmr_compare #(.HALF_W(HALF_W)) u_cmp (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt_i     (cnt),
      .en_i      (ctl_q.cmp_en),
      .step_en_i (ctl_q.step_en),
      .step_i    (step_q),
      .wr_lo_i   (wr_cmp_lo),
      .wr_hi_i   (wr_cmp_hi),
      .wdata_i   (bus_wdata),
      .cmp_o     (cmp),
      .hit_o     (hit)
   );

   always_comb begin
      ctrl_rd           = '0;
      ctrl_rd[CB_RUN]   = ctl_q.run;
      ctrl_rd[CB_CMP]   = ctl_q.cmp_en;
      ctrl_rd[CB_IRQ]   = ctl_q.irq_en;
      ctrl_rd[CB_STEP]  = ctl_q.step_en;
      for (int i = 0; i < PSC_W; i++) ctrl_rd[CB_DIV_LSB + i] = div_q[i];
   end

   always_comb begin
      rd_mux = '0;
      if (bus_addr == ADDR_W'(OFF_CNT_LO))      rd_mux = cnt[HALF_W-1:0];
      else if (bus_addr == ADDR_W'(OFF_CNT_HI)) rd_mux = cnt[CNT_W-1:HALF_W];
      else if (bus_addr == ADDR_W'(OFF_CTRL))   rd_mux = ctrl_rd;
      else if (bus_addr == ADDR_W'(OFF_STAT))   rd_mux = {31'b0, flag_q};
      else if (bus_addr == ADDR_W'(OFF_CMP_LO)) rd_mux = cmp[HALF_W-1:0];
      else if (bus_addr == ADDR_W'(OFF_CMP_HI)) rd_mux = cmp[CNT_W-1:HALF_W];
      else if (bus_addr == ADDR_W'(OFF_STEP))   rd_mux = step_q;
   end

   assign bus_rdata = (bus_sel && !bus_wr) ? rd_mux : '0;
   assign irq_o     = flag_q & ctl_q.irq_en;

   // R5
   flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(hit));
   // R6
   cmp_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_q.cmp_en |=> !$rose(flag_q));
   // R4
   cnt_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q.run && !tick) |=> $stable(cnt));
   // R7
   w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && bus_wdata[0] && !hit) |=> !flag_q);
   // R9
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !wr_ctrl && !wr_stat) |=> irq_o);
endmodule

// File: tb/cmp_timer64_bench.sv
module cmp_timer64_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_o;

   always #2 clk = ~clk;   // 250 MHz

   cmp_timer64 u_cmp_timer64 (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_o     (irq_o)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   // Reference state, derived from the requirements
   logic [63:0] m_cnt, m_cmp;
   logic [31:0] m_step;
   logic [7:0]  m_div, m_pc;
   logic        m_run, m_cen, m_ien, m_sen, m_flag;

   task automatic m_reset();
      m_cnt = '0; m_cmp = '0; m_step = '0; m_div = '0; m_pc = '0;
      m_run = 0; m_cen = 0; m_ien = 0; m_sen = 0; m_flag = 0;
   endtask

   function automatic logic [31:0] m_read(input logic [4:0] a);
      case (a)
         5'h00:   return m_cnt[31:0];
         5'h04:   return m_cnt[63:32];
         5'h08:   return {16'b0, m_div, 4'b0, m_sen, m_ien, m_cen, m_run};
         5'h0C:   return {31'b0, m_flag};
         5'h10:   return m_cmp[31:0];
         5'h14:   return m_cmp[63:32];
         5'h18:   return m_step;
         default: return 32'h0;
      endcase
   endfunction

   task automatic m_step_edge(input bit s, input bit w, input logic [4:0] a, input logic [31:0] d);
      logic        tick, hit, we;
      logic [63:0] n_cnt, n_cmp;
      logic [7:0]  n_pc;
      logic        n_flag;
      we   = s && w;
      tick = m_run && (m_pc >= m_div);
      hit  = m_cen && (m_cnt >= m_cmp);
      n_pc = (!m_run || tick) ? 8'h0 : m_pc + 8'h1;
      n_cnt = m_cnt;
      if (we && !m_run && (a == 5'h00 || a == 5'h04)) begin
         if (a == 5'h00) n_cnt[31:0]  = d;
         else            n_cnt[63:32] = d;
      end else if (tick) n_cnt = m_cnt + 64'd1;
      n_cmp = m_cmp;
      if (we && (a == 5'h10 || a == 5'h14)) begin
         if (a == 5'h10) n_cmp[31:0]  = d;
         else            n_cmp[63:32] = d;
      end else if (hit && m_sen) n_cmp = m_cmp + {32'b0, m_step};
      n_flag = hit ? 1'b1 : ((we && a == 5'h0C && d[0]) ? 1'b0 : m_flag);
      if (we && a == 5'h08) begin
         m_run = d[0]; m_cen = d[1]; m_ien = d[2]; m_sen = d[3]; m_div = d[15:8];
      end
      if (we && a == 5'h18) m_step = d;
      m_pc = n_pc; m_cnt = n_cnt; m_cmp = n_cmp; m_flag = n_flag;
   endtask

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic cyc(input bit s, input bit w, input logic [4:0] a, input logic [31:0] d, input string tag);
      @(negedge clk);
      bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
      #1;
      if (s && !w) chk(bus_rdata, m_read(a), tag);
      chk({31'b0, irq_o}, {31'b0, m_flag & m_ien}, "R9 irq level");
      @(posedge clk);
      m_step_edge(s, w, a, d);
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d, input string tag);
      cyc(1, 1, a, d, tag);
   endtask
   task automatic rd(input logic [4:0] a, input string tag);
      cyc(1, 0, a, 32'h0, tag);
   endtask
   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(0, 0, 5'h0, 32'h0, "R9");
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   function automatic string tag_of(input logic [4:0] a);
      case (a)
         5'h00, 5'h04: return "R3 count";
         5'h0C:        return "R5 status";
         5'h10, 5'h14: return "R8 comparator";
         default:      return "R2 window";
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      r = $urandom(32'd20240611);
      m_reset();
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      for (int a = 0; a <= 'h18; a += 4) rd(5'(a), "R1 reset");
      chk({31'b0, irq_o}, 32'h0, "R1 irq");

      // R2 unmapped offsets
      wr(5'h1C, 32'hDEAD_BEEF, "R2");
      rd(5'h1C, "R2 unmapped read");
      rd(5'h03, "R2 misaligned read");
      rd(5'h08, "R2 ctrl untouched");

      // R4 load while stopped, R10 carry
      wr(5'h00, 32'hFFFF_FFFA, "R4");
      wr(5'h04, 32'h0000_0007, "R4");
      rd(5'h00, "R4 lo loaded");
      rd(5'h04, "R4 hi loaded");
      wr(5'h08, 32'h0000_0001, "R3");
      idle(8);
      rd(5'h04, "R10 carry into high half");
      rd(5'h00, "R3 P=0 rate");
      wr(5'h00, 32'h0000_1234, "R4");
      rd(5'h00, "R4 write ignored while running");

      // R3 divide by 4, then stop
      wr(5'h08, 32'h0000_0301, "R3");
      idle(10);
      rd(5'h00, "R3 P=3 rate");
      rd(5'h08, "R2 divide field");
      wr(5'h08, 32'h0000_0300, "R3");
      idle(5);
      rd(5'h00, "R3 held when stopped");
      rd(5'h00, "R3 held when stopped");

      // R6 comparator below count but disabled
      wr(5'h10, 32'h0, "R6");
      wr(5'h14, 32'h7, "R6");
      idle(3);
      rd(5'h0C, "R6 no event while disabled");

      // R5 greater-or-equal fires
      wr(5'h08, 32'h0000_0303, "R5");
      rd(5'h0C, "R5 first cycle");
      rd(5'h0C, "R5 flag set");

      // R7 write-one-clear
      wr(5'h0C, 32'h0, "R7");
      rd(5'h0C, "R7 write zero no effect");
      wr(5'h0C, 32'h1, "R7");
      rd(5'h0C, "R7 event wins over clear");

      // R9 interrupt level
      wr(5'h08, 32'h0000_0307, "R9");
      idle(3);
      wr(5'h08, 32'h0000_0305, "R9");
      wr(5'h14, 32'h8, "R9");
      idle(2);
      wr(5'h0C, 32'h1, "R7");
      rd(5'h0C, "R7 flag cleared");
      idle(2);

      // R8 periodic auto-step
      wr(5'h08, 32'h0000_0001, "R8");
      wr(5'h10, m_cnt[31:0] + 32'd20, "R8");
      wr(5'h14, m_cnt[63:32], "R8");
      wr(5'h18, 32'd7, "R8");
      wr(5'h08, 32'h0000_000F, "R8");
      for (int k = 0; k < 12; k++) begin
         idle(3);
         rd(5'h10, "R8 comparator stepped");
         rd(5'h0C, "R8 periodic flag");
         wr(5'h0C, 32'h1, "R7");
      end
      wr(5'h08, 32'h0, "R8");

      // Random phase
      for (int i = 0; i < 4000; i++) begin
         int unsigned op;
         logic [4:0] a;
         logic [31:0] d;
         op = $urandom % 10;
         a  = 5'(($urandom % 8) * 4);
         if (($urandom % 16) == 0) a = 5'($urandom);
         d = $urandom;
         if (op < 5) begin
            rd(a, tag_of(a));
         end else if (op < 9) begin
            case (a)
               5'h08: d = {16'b0, 8'($urandom % 4), 4'b0, 4'($urandom)};
               5'h10: d = m_cnt[31:0] + ($urandom % 64);
               5'h14: d = m_cnt[63:32];
               5'h18: d = 1 + ($urandom % 16);
               default: ;
            endcase
            wr(a, d, tag_of(a));
         end else begin
            idle(1);
         end
      end

      done = 1;
      summary();
      $finish;
   end
endmodule